// File: doc/BRIEF.md
# Display Character and Attribute Store with Microprocessor Write Port

This block holds everything a four-digit dot-matrix display controller remembers: one 7-bit character code for each digit, two attribute bits for each digit (cursor select and blank override), and a 5-bit control word made of a master blank flag, a 3-bit brightness code and a flag that turns off the extended functions. The refresh, blanking and font logic downstream read these values straight from the output ports.

A processor writes the store through a port that has no clock of its own. The port has two active-low chip enables, an active-low write strobe, a 2-bit digit address, a target select and seven data bits. Every one of these pins passes through a two-stage synchroniser into the system clock domain. A write takes effect when the synchronised strobe goes from low to high. The select line chooses between the character store and the combined attribute/control store. A separate active-low clear input puts every location back to its initial value, but only when it stays low long enough. The minimum duration is measured in system clocks and derived from the `CLK_HZ` and `CLR_MIN_NS` parameters. A shorter low pulse is treated as a glitch and does nothing.

Top module: `dispreg_wport`

## Requirements
- R1: After reset, every character slot holds 0x20 and all attribute bits and control fields are 0.
- R2: A write with `to_char`=1 stores `wdata` in the slot `waddr`. Slot n occupies `char_codes[7n+6:7n]`. Slot 0 is the rightmost digit and slot 3 is the leftmost.
- R3: A write leaves all stored state unchanged when either `ce_a_n` or `ce_b_n` is 1.
- R4: A write with `to_char`=0 sets `cursor_en[waddr]` to `wdata[0]` and `blank_hold[waddr]` to `wdata[1]`. The other digits' attribute bits stay as they were.
- R5: Every write with `to_char`=0, at any address, loads `master_blank` from `wdata[2]`, `bright_code` from `wdata[5:3]` and `ext_off` from `wdata[6]`.
- R6: Address, select, enables and data are taken from the last clock edge at which the strobe was still sampled low. The stored value appears after the third rising clock edge that samples `wstb_n` high.
- R7: While `wstb_n` stays at one level, whether held low or held high, nothing is written.
- R8: If `clear_n` is sampled low on N consecutive clock edges, all state returns to the R1 values whatever the enables are. N = ceil(CLK_HZ·CLR_MIN_NS/1e9), which is 2500 by default. A pulse of N-1 samples changes nothing.
- R9: The clear keeps the state at the R1 values while it stays in force. A write that commits in the same cycle as the clear is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_a_n | input | 1 | Chip enable A, active low |
| ce_b_n | input | 1 | Chip enable B, active low |
| wstb_n | input | 1 | Write strobe; a write commits on its rising edge |
| waddr | input | 2 | Digit address, 0 = rightmost |
| to_char | input | 1 | 1 = character store, 0 = attribute/control |
| wdata | input | 7 | Write data |
| clear_n | input | 1 | Active-low clear with minimum duration |
| char_codes | output | 28 | Four 7-bit character codes, slot 0 in the low bits |
| cursor_en | output | 4 | Cursor bit for each digit |
| blank_hold | output | 4 | Blank-override bit for each digit |
| master_blank | output | 1 | Master blank flag |
| bright_code | output | 3 | Brightness code |
| ext_off | output | 1 | Extended-function disable flag |

## Verification
A write commit and the clear can act in the same cycle. The bench provokes this by holding `clear_n` low past the qualifying length and completing a full strobe cycle while the clear is still in force. A second strobe rise is placed so that its commit edge falls in the last cycles of the clear enforcement, after `clear_n` has already been released. The behavioural model in the bench, compared on every clock, expects the clear to win in both cases and the stored space code to survive. A following write is then checked to land normally.

// File: rtl/dispreg_wport.sv
module dispreg_wport #(
  parameter int CLK_HZ     = 250_000_000,
  parameter int CLR_MIN_NS = 10_000,
  parameter int DIGITS     = 4,
  parameter int CODE_W     = 7,
  parameter int AW         = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     ce_a_n,
  input  logic                     ce_b_n,
  input  logic                     wstb_n,
  input  logic [AW-1:0]            waddr,
  input  logic                     to_char,
  input  logic [CODE_W-1:0]        wdata,
  input  logic                     clear_n,
  output logic [DIGITS*CODE_W-1:0] char_codes,
  output logic [DIGITS-1:0]        cursor_en,
  output logic [DIGITS-1:0]        blank_hold,
  output logic                     master_blank,
  output logic [2:0]               bright_code,
  output logic                     ext_off
);
  localparam longint CLR_L   = (longint'(CLK_HZ) * longint'(CLR_MIN_NS) + 64'd999_999_999) / 64'd1_000_000_000;
  localparam int     CLR_CYC = (CLR_L < 1) ? 1 : int'(CLR_L);
  localparam int     CW      = $clog2(CLR_CYC + 1);

  localparam int B_SEL = CODE_W + AW;
  localparam int B_CEA = B_SEL + 1;
  localparam int B_CEB = B_SEL + 2;
  localparam int B_WR  = B_SEL + 3;
  localparam int B_CLR = B_SEL + 4;
  localparam int BW    = B_CLR + 1;

  localparam logic [BW-1:0]     IDLE  = {1'b1, 1'b1, 1'b1, 1'b1, 1'b0, {AW{1'b0}}, {CODE_W{1'b0}}};
  localparam logic [CODE_W-1:0] SPACE = CODE_W'(32);

  logic [BW-1:0] raw, s1, s2;
  logic [B_CLR-1:0] s3;
  logic [CW-1:0] clr_cnt;

  logic [DIGITS-1:0][CODE_W-1:0] char_q;

  logic              commit, clr_act, sel_p;
  logic [AW-1:0]     addr_p;
  logic [CODE_W-1:0] data_p;

  assign raw = {clear_n, wstb_n, ce_b_n, ce_a_n, to_char, waddr, wdata};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= IDLE;
      s2 <= IDLE;
      s3 <= IDLE[B_CLR-1:0];
    end else begin
      s1 <= raw;
      s2 <= s1;
      s3 <= s2[B_CLR-1:0];
    end
  end

  assign sel_p  = s3[B_SEL];
  assign addr_p = s3[B_SEL-1:CODE_W];
  assign data_p = s3[CODE_W-1:0];
  assign commit = s2[B_WR] & ~s3[B_WR] & ~s3[B_CEA] & ~s3[B_CEB];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      clr_cnt <= '0;
    else if (s2[B_CLR])
      clr_cnt <= '0;
    else if (clr_cnt != CW'(CLR_CYC))
      clr_cnt <= clr_cnt + 1'b1;
  end

  assign clr_act = (clr_cnt == CW'(CLR_CYC));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      char_q       <= {DIGITS{SPACE}};
      cursor_en    <= '0;
      blank_hold   <= '0;
      master_blank <= 1'b0;
      bright_code  <= '0;
      ext_off      <= 1'b0;
    end else if (clr_act) begin
      char_q       <= {DIGITS{SPACE}};
      cursor_en    <= '0;
      blank_hold   <= '0;
      master_blank <= 1'b0;
      bright_code  <= '0;
      ext_off      <= 1'b0;
    end else if (commit) begin
      if (sel_p) begin
        char_q[addr_p] <= data_p;
      end else begin
        cursor_en[addr_p]  <= data_p[0];
        blank_hold[addr_p] <= data_p[1];
        master_blank       <= data_p[2];
        bright_code        <= data_p[5:3];
        ext_off            <= data_p[6];
      end
    end
  end

  assign char_codes = char_q;

endmodule

// File: rtl/dispreg_wport_chk.sv
module dispreg_wport_chk #(
  parameter int DIGITS = 4,
  parameter int CODE_W = 7,
  parameter int AW     = 2
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     commit,
  input logic                     clr_act,
  input logic                     sel_p,
  input logic [AW-1:0]            addr_p,
  input logic [CODE_W-1:0]        data_p,
  input logic                     ce_a_s,
  input logic                     ce_b_s,
  input logic [DIGITS*CODE_W-1:0] char_codes,
  input logic [DIGITS-1:0]        cursor_en,
  input logic [DIGITS-1:0]        blank_hold,
  input logic                     master_blank,
  input logic [2:0]               bright_code,
  input logic                     ext_off
);
  logic [DIGITS*CODE_W+2*DIGITS+4:0] all_state;
  assign all_state = {char_codes, cursor_en, blank_hold, master_blank, bright_code, ext_off};

  a_r3_disabled_chip_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_act && (ce_a_s || ce_b_s)) |=> $stable(all_state));

  a_r7_no_edge_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_act && !commit) |=> $stable(all_state));

  a_r8_clear_restores: assert property (@(posedge clk) disable iff (!rst_n)
    clr_act |=> (char_codes == {DIGITS{CODE_W'(32)}} && cursor_en == '0 && blank_hold == '0
                 && !master_blank && bright_code == 3'd0 && !ext_off));

  a_r5_ctrl_fields: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_act && commit && !sel_p) |=> ({ext_off, bright_code, master_blank} == $past(data_p[6:2])));

  a_r2_char_slot: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_act && commit && sel_p) |=> (char_codes[CODE_W*$past(addr_p) +: CODE_W] == $past(data_p)));

  a_r4_attr_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_act && commit && !sel_p) |=> (cursor_en[$past(addr_p)] == $past(data_p[0])
                                        && blank_hold[$past(addr_p)] == $past(data_p[1])));
endmodule

bind dispreg_wport dispreg_wport_chk #(.DIGITS(DIGITS), .CODE_W(CODE_W), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .commit(commit), .clr_act(clr_act), .sel_p(sel_p),
  .addr_p(addr_p), .data_p(data_p), .ce_a_s(s3[B_CEA]), .ce_b_s(s3[B_CEB]),
  .char_codes(char_codes), .cursor_en(cursor_en), .blank_hold(blank_hold),
  .master_blank(master_blank), .bright_code(bright_code), .ext_off(ext_off)
);

// File: tb/dispreg_wport_tb.sv
module dispreg_wport_tb;
  localparam int N = 2500;

  logic clk = 0, rst_n = 0;
  logic ce_a_n = 1, ce_b_n = 1, wstb_n = 1, to_char = 0, clear_n = 1;
  logic [1:0] waddr = 0;
  logic [6:0] wdata = 0;
  logic [27:0] char_codes;
  logic [3:0] cursor_en, blank_hold;
  logic master_blank, ext_off;
  logic [2:0] bright_code;

  int checks = 0, failures = 0, cyc = 0;
  bit done = 0;

  always #2 clk = ~clk;

  dispreg_wport u_dut (.clk(clk), .rst_n(rst_n), .ce_a_n(ce_a_n), .ce_b_n(ce_b_n),
    .wstb_n(wstb_n), .waddr(waddr), .to_char(to_char), .wdata(wdata), .clear_n(clear_n),
    .char_codes(char_codes), .cursor_en(cursor_en), .blank_hold(blank_hold),
    .master_blank(master_blank), .bright_code(bright_code), .ext_off(ext_off));

  // reference model: input history, newest first
  logic [13:0] hist[$];
  logic [6:0] m_chr[4];
  logic [3:0] m_cur, m_bh;
  logic m_mb, m_ext;
  logic [2:0] m_br;
  int m_cnt;
  localparam logic [13:0] IDLE = 14'b1111_0000_0000_00;

  task automatic m_clear();
    for (int i = 0; i < 4; i++) m_chr[i] = 7'h20;
    m_cur = 0; m_bh = 0; m_mb = 0; m_br = 0; m_ext = 0;
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_clear();
      m_cnt = 0;
      hist = {};
      for (int i = 0; i < 4; i++) hist.push_front(IDLE);
    end else begin
      logic [13:0] p2, p3;
      bit fire;
      hist.push_front({clear_n, wstb_n, ce_b_n, ce_a_n, to_char, waddr, wdata});
      if (hist.size() > 6) void'(hist.pop_back());
      p2 = hist[2]; p3 = hist[3];
      fire = (m_cnt == N);
      if (p2[13]) m_cnt = 0; else if (m_cnt < N) m_cnt++;
      if (fire) m_clear();
      else if (p2[12] && !p3[12] && !p3[11] && !p3[10]) begin
        if (p3[9]) m_chr[p3[8:7]] = p3[6:0];
        else begin
          m_cur[p3[8:7]] = p3[0];
          m_bh[p3[8:7]]  = p3[1];
          m_mb = p3[2]; m_br = p3[5:3]; m_ext = p3[6];
        end
      end
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R2 model char_codes", 32'(char_codes), 32'({m_chr[3], m_chr[2], m_chr[1], m_chr[0]}));
      chk("R4 model attributes", 32'({cursor_en, blank_hold}), 32'({m_cur, m_bh}));
      chk("R5 model control", 32'({ext_off, bright_code, master_blank}), 32'({m_ext, m_br, m_mb}));
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000 && !done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic ncyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(bit sel, logic [1:0] a, logic [6:0] d, bit cea = 0, bit ceb = 0);
    ce_a_n = cea; ce_b_n = ceb; to_char = sel; waddr = a; wdata = d; wstb_n = 0;
    ncyc(3);
    wstb_n = 1;
    ncyc(3);
    ce_a_n = 1; ce_b_n = 1;
    ncyc(1);
  endtask

  initial begin
    ncyc(3);
    rst_n = 1;
    ncyc(2);
    chk("R1 chars after reset", 32'(char_codes), 32'({4{7'h20}}));
    chk("R1 attr/ctrl after reset", 32'({cursor_en, blank_hold, master_blank, bright_code, ext_off}), 0);

    wr(1, 3, 7'h48); wr(1, 2, 7'h45); wr(1, 1, 7'h4C); wr(1, 0, 7'h50);
    chk("R2 four slots, slot0 rightmost", 32'(char_codes), 32'({7'h48, 7'h45, 7'h4C, 7'h50}));
    wr(1, 1, 7'h7F);
    chk("R2 overwrite slot1", 32'(char_codes[13:7]), 32'h7F);

    wr(1, 0, 7'h11, 1, 0);
    chk("R3 ce_a high ignored", 32'(char_codes), 32'({7'h48, 7'h45, 7'h7F, 7'h50}));
    wr(0, 2, 7'h7F, 0, 1);
    chk("R3 ce_b high ignored", 32'({cursor_en, blank_hold, master_blank, bright_code, ext_off}), 0);

    wr(0, 2, 7'b1010011);
    chk("R4 digit2 attr set", 32'({cursor_en, blank_hold}), 32'({4'b0100, 4'b0100}));
    chk("R5 ctrl from attr write", 32'({ext_off, bright_code, master_blank}), 32'({1'b1, 3'b010, 1'b0}));
    wr(0, 0, 7'b0111101);
    chk("R4 digit0 set, digit2 kept", 32'({cursor_en, blank_hold}), 32'({4'b0101, 4'b0100}));
    chk("R5 ctrl any address", 32'({ext_off, bright_code, master_blank}), 32'({1'b0, 3'b111, 1'b1}));

    // R6: data changes together with the strobe rise; the earlier value must be stored
    ce_a_n = 0; ce_b_n = 0; to_char = 1; waddr = 2; wdata = 7'h31; wstb_n = 0;
    ncyc(3);
    wstb_n = 1; wdata = 7'h32;
    ncyc(2);
    chk("R6 not yet after two edges", 32'(char_codes[20:14]), 32'h45);
    ncyc(1);
    chk("R6 stored on third edge, prior data", 32'(char_codes[20:14]), 32'h31);
    ce_a_n = 1; ce_b_n = 1;
    ncyc(2);

    // R7: strobe held low, then held high, with data moving
    ce_a_n = 0; ce_b_n = 0; to_char = 1; waddr = 3; wstb_n = 0;
    for (int i = 0; i < 8; i++) begin wdata = 7'(i); ncyc(1); end
    chk("R7 strobe held low", 32'(char_codes[27:21]), 32'h48);
    ce_a_n = 1; ncyc(2); wstb_n = 1; ncyc(4);
    ce_a_n = 0;
    for (int i = 0; i < 8; i++) begin waddr = 2'(i); wdata = 7'(i + 9); ncyc(1); end
    chk("R7 strobe held high", 32'(char_codes), 32'({7'h48, 7'h31, 7'h7F, 7'h50}));
    ce_a_n = 1; ce_b_n = 1;
    ncyc(2);

    // R8: short clear ignored, full-length clear with chips enabled
    clear_n = 0; ncyc(N - 1); clear_n = 1; ncyc(8);
    chk("R8 short clear ignored", 32'(char_codes), 32'({7'h48, 7'h31, 7'h7F, 7'h50}));
    ce_a_n = 0; ce_b_n = 0;
    clear_n = 0; ncyc(N); clear_n = 1; ncyc(8);
    chk("R8 full clear chars", 32'(char_codes), 32'({4{7'h20}}));
    chk("R8 full clear attr/ctrl", 32'({cursor_en, blank_hold, master_blank, bright_code, ext_off}), 0);
    ce_a_n = 1; ce_b_n = 1;

    // R9: write during held clear is lost; commit landing in the clear's tail too
    wr(1, 1, 7'h55);
    clear_n = 0; ncyc(N + 4);
    wr(1, 1, 7'h66);
    chk("R9 write under clear lost", 32'(char_codes[13:7]), 32'h20);
    ce_a_n = 0; ce_b_n = 0; to_char = 1; waddr = 0; wdata = 7'h67; wstb_n = 0;
    ncyc(3);
    clear_n = 1; wstb_n = 1;
    ncyc(5);
    chk("R9 commit coinciding with clear tail lost", 32'(char_codes[6:0]), 32'h20);
    ce_a_n = 1; ce_b_n = 1;
    ncyc(2);
    wr(1, 0, 7'h68);
    chk("R9 write after clear lands", 32'(char_codes[6:0]), 32'h68);

    ncyc(4);
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule